// File: doc/BRIEF.md
# Eight-Source Vectored Interrupt Controller

This block arbitrates eight interrupt sources for a host. Every source owns four state bits: a pending request, a mask, an in-service flag and an auto-clear flag. It also owns one entry in an eight-entry vector table. The host sees two 16-bit registers, chosen by a one-bit select.

- The command/status register takes encoded commands when written and returns controller status when read.
- The data register reaches whichever target the last preselect command chose. That target is the mask, the auto-clear register or one vector entry.

Sources raise and drop requests with single-cycle set and clear pulses. The block flags a group interrupt whenever the master-mask mode bit is on and some request is unmasked. Its single request output follows that flag, gated by an external enable.

During an acknowledge cycle the block drives the vector of the winning source. At the closing clock edge it updates that source's request and in-service state. Reads are combinational: the read data follows the select and the current state in the same cycle.

Top module: `vic_intc`

## Requirements
- R1: After reset the mode register is 0x80. The mask is 0xFF. Request, in-service and auto-clear are all 0. The data-register target is vector entry 0. All vector entries are 0.
- R2: A write with select 1 is a command. The command code is write-data bits 7:4. If bit 3 is 1, the command acts only on the source numbered by bits 2:0. If bit 3 is 0, it acts on all eight sources.
- R3: Command 0 sets the mask to all ones and clears request, in-service and auto-clear. It leaves the mode register and the data-register target unchanged.
- R4: The bit commands are as follows. Codes 1, 5, 6, 13 and 15 change nothing.
  - Command 2 clears the selected request and mask bits.
  - Command 3 sets the selected mask bits.
  - Command 4 clears the selected request bits.
  - Command 7 clears the selected in-service bits.
- R5: The data-register target is set by three commands and holds until the next one of them. A write with select 0 stores into the current target. The mask and auto-clear take data bits 7:0; a vector entry takes the full word.
  - Command 11 selects the mask.
  - Command 12 selects the auto-clear register.
  - Command 14 selects the vector entry numbered by data bits 2:0.
- R6: Command 8 or 9 loads mode bits 4:0 from data bits 4:0. Command 10 loads mode bits 6:5 from data bits 3:2. When data bits 1:0 are 01 or 10, command 10 also loads mode bit 7 from data bit 0.
- R7: A read with select 0 returns, zero-extended, the register chosen by mode bits 6:5:
  - 0 returns in-service.
  - 1 returns mask.
  - 2 returns request.
  - 3 returns auto-clear.
- R8: A read with select 1 returns the status word. Bits 15:8 are 0.
  - Bit 7 is the group flag.
  - Bit 6 is 1.
  - Bit 5 is mode bit 0.
  - Bit 4 is mode bit 2.
  - Bit 3 is mode bit 7.
  - Bits 2:0 give the lowest set in-service index when the group flag is 1, and 0 otherwise.
- R9: The group flag is mode bit 7 ANDed with "any request bit set whose mask bit is clear". The request output equals the group flag ANDed with the enable input, in the same cycle.
- R10: Acknowledge works as follows.
  - While acknowledge is high, the winner is the lowest-numbered source that is requesting and unmasked. The vector output carries that source's entry, or 0 if no source qualifies.
  - At the edge, the winner's request bit clears.
  - The winner's in-service bit clears if its auto-clear bit is set, and is set otherwise.
- R11: A source set pulse sets that source's request bit at the next edge. A source clear pulse clears both its request and in-service bits, and wins over a set pulse in the same cycle. Source pulses take effect after the same cycle's command and acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostWrEn | input | 1 | Host write strobe |
| hostSel | input | 1 | 1 selects command/status, 0 selects data register |
| hostWrData | input | 16 | Host write data |
| hostRdData | output | 16 | Combinational read data for the selected register |
| srcSet | input | 8 | Per-source request set pulses |
| srcClr | input | 8 | Per-source request and in-service clear pulses |
| intAck | input | 1 | Acknowledge cycle strobe |
| ackVector | output | 16 | Winning vector during acknowledge, 0 if none |
| intEnable | input | 1 | External gate for the request output |
| irqOut | output | 1 | Group interrupt request |

## Verification
The bench targets the priority corner cases.

- An acknowledge with a masked-only request must return vector 0. A design that ignored the mask would hand back a stale entry.
- The auto-clear bit must decide whether the in-service bit survives an acknowledge. Inverting it would leave the status index pointing at the wrong source.
- A clear and a set pulse on one source in the same cycle must leave the request low.
- Undefined command codes must change nothing.
- Command 10 must move the master-mask bit only for the two codes that name it. A wrong decode would silence or wrongly raise the request output.

A random phase mixes commands, data writes, pulses and acknowledges. It compares every output against a behavioural model on every clock.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int NSRC   = 8;
  localparam int IDX_W  = $clog2(NSRC);
  localparam int HOST_W = 16;
  localparam int MODE_W = 8;

  localparam logic [3:0] CMD_RESET    = 4'd0;
  localparam logic [3:0] CMD_CLR_RQMK = 4'd2;
  localparam logic [3:0] CMD_SET_MASK = 4'd3;
  localparam logic [3:0] CMD_CLR_REQ  = 4'd4;
  localparam logic [3:0] CMD_CLR_SVC  = 4'd7;
  localparam logic [3:0] CMD_MODE_LO  = 4'd8;
  localparam logic [3:0] CMD_MODE_HI  = 4'd9;
  localparam logic [3:0] CMD_MODE_CTL = 4'd10;
  localparam logic [3:0] CMD_PT_MASK  = 4'd11;
  localparam logic [3:0] CMD_PT_AUTO  = 4'd12;
  localparam logic [3:0] CMD_PT_VEC   = 4'd14;

  typedef enum logic [1:0] {PT_VEC, PT_MASK, PT_AUTO} ptr_kind_e;

  typedef struct packed {
    logic             rstAll;
    logic             clrReq;
    logic             clrMask;
    logic             setMask;
    logic             clrSvc;
    logic             wrVec;
    logic             wrMask;
    logic             wrAuto;
    logic [NSRC-1:0]  bitSel;
    logic [IDX_W-1:0] vecIdx;
  } vic_strobe_t;
endpackage

// File: rtl/vic_prio.sv
module vic_prio #(
  parameter int N     = 8,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     bits,
  output logic             hit,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (bits[i]) begin
        hit = 1'b1;
        idx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/vic_ctrl.sv
module vic_ctrl
  import vic_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostWrEn,
  input  logic              hostSel,
  input  logic [HOST_W-1:0] hostWrData,
  output vic_strobe_t       strobes,
  output logic [MODE_W-1:0] modeReg
);
  ptr_kind_e        ptrKind;
  logic [IDX_W-1:0] ptrIdx;
  logic             cmdWr;
  logic             dataWr;
  logic [3:0]       cmdCode;

  assign cmdWr   = hostWrEn & hostSel;
  assign dataWr  = hostWrEn & ~hostSel;
  assign cmdCode = hostWrData[7:4];

  always_comb begin
    strobes        = '0;
    strobes.bitSel = hostWrData[3] ? (NSRC'(1) << hostWrData[IDX_W-1:0]) : '1;
    strobes.vecIdx = ptrIdx;
    if (cmdWr) begin
      case (cmdCode)
        CMD_RESET:    strobes.rstAll = 1'b1;
        CMD_CLR_RQMK: begin
          strobes.clrReq  = 1'b1;
          strobes.clrMask = 1'b1;
        end
        CMD_SET_MASK: strobes.setMask = 1'b1;
        CMD_CLR_REQ:  strobes.clrReq  = 1'b1;
        CMD_CLR_SVC:  strobes.clrSvc  = 1'b1;
        default: ;
      endcase
    end
    if (dataWr) begin
      case (ptrKind)
        PT_MASK: strobes.wrMask = 1'b1;
        PT_AUTO: strobes.wrAuto = 1'b1;
        default: strobes.wrVec  = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeReg <= MODE_W'(8'h80);
      ptrKind <= PT_VEC;
      ptrIdx  <= '0;
    end else if (cmdWr) begin
      case (cmdCode)
        CMD_MODE_LO, CMD_MODE_HI: modeReg[4:0] <= hostWrData[4:0];
        CMD_MODE_CTL: begin
          modeReg[6:5] <= hostWrData[3:2];
          if (hostWrData[1:0] == 2'b01 || hostWrData[1:0] == 2'b10)
            modeReg[7] <= hostWrData[0];
        end
        CMD_PT_MASK: ptrKind <= PT_MASK;
        CMD_PT_AUTO: ptrKind <= PT_AUTO;
        CMD_PT_VEC: begin
          ptrKind <= PT_VEC;
          ptrIdx  <= hostWrData[IDX_W-1:0];
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/vic_datapath.sv
module vic_datapath
  import vic_pkg::*;
#(
  parameter int VEC_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  vic_strobe_t       strobes,
  input  logic [HOST_W-1:0] hostWrData,
  input  logic              intAck,
  input  logic [NSRC-1:0]   srcSet,
  input  logic [NSRC-1:0]   srcClr,
  output logic [NSRC-1:0]   reqBits,
  output logic [NSRC-1:0]   maskBits,
  output logic [NSRC-1:0]   svcBits,
  output logic [NSRC-1:0]   autoBits,
  output logic [VEC_W-1:0]  ackVector
);
  logic [VEC_W-1:0] vecMem [NSRC];
  logic [NSRC-1:0]  reqNext, maskNext, svcNext, autoNext;
  logic [NSRC-1:0]  unmasked;
  logic             winHit;
  logic [IDX_W-1:0] winIdx;

  assign unmasked = reqBits & ~maskBits;

  vic_prio #(.N(NSRC), .IDX_W(IDX_W)) u_winPrio (
    .bits(unmasked), .hit(winHit), .idx(winIdx)
  );

  assign ackVector = (intAck && winHit) ? vecMem[winIdx] : '0;

  always_comb begin
    reqNext  = reqBits;
    maskNext = maskBits;
    svcNext  = svcBits;
    autoNext = autoBits;
    if (strobes.rstAll) begin
      reqNext  = '0;
      maskNext = '1;
      svcNext  = '0;
      autoNext = '0;
    end
    if (strobes.clrReq)  reqNext  = reqNext & ~strobes.bitSel;
    if (strobes.clrMask) maskNext = maskNext & ~strobes.bitSel;
    if (strobes.setMask) maskNext = maskNext | strobes.bitSel;
    if (strobes.clrSvc)  svcNext  = svcNext & ~strobes.bitSel;
    if (strobes.wrMask)  maskNext = hostWrData[NSRC-1:0];
    if (strobes.wrAuto)  autoNext = hostWrData[NSRC-1:0];
    if (intAck && winHit) begin
      reqNext[winIdx] = 1'b0;
      svcNext[winIdx] = ~autoBits[winIdx];
    end
    reqNext = (reqNext | srcSet) & ~srcClr;
    svcNext = svcNext & ~srcClr;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqBits  <= '0;
      maskBits <= '1;
      svcBits  <= '0;
      autoBits <= '0;
    end else begin
      reqBits  <= reqNext;
      maskBits <= maskNext;
      svcBits  <= svcNext;
      autoBits <= autoNext;
    end
  end

  for (genvar g = 0; g < NSRC; g++) begin : g_vec
    always_ff @(posedge clk) begin
      if (!rstN)
        vecMem[g] <= '0;
      else if (strobes.wrVec && strobes.vecIdx == IDX_W'(g))
        vecMem[g] <= hostWrData[VEC_W-1:0];
    end
  end
endmodule

// File: rtl/vic_intc.sv
module vic_intc
  import vic_pkg::*;
#(
  parameter int VEC_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostWrEn,
  input  logic              hostSel,
  input  logic [HOST_W-1:0] hostWrData,
  output logic [HOST_W-1:0] hostRdData,
  input  logic [NSRC-1:0]   srcSet,
  input  logic [NSRC-1:0]   srcClr,
  input  logic              intAck,
  output logic [VEC_W-1:0]  ackVector,
  input  logic              intEnable,
  output logic              irqOut
);
  vic_strobe_t       strobes;
  logic [MODE_W-1:0] modeReg;
  logic [NSRC-1:0]   reqBits, maskBits, svcBits, autoBits;
  logic              groupFlag;
  logic              svcHit;
  logic [IDX_W-1:0]  svcIdx;
  logic [NSRC-1:0]   dataSel;

  vic_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .hostWrEn(hostWrEn), .hostSel(hostSel),
    .hostWrData(hostWrData), .strobes(strobes), .modeReg(modeReg)
  );

  vic_datapath #(.VEC_W(VEC_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .hostWrData(hostWrData),
    .intAck(intAck), .srcSet(srcSet), .srcClr(srcClr),
    .reqBits(reqBits), .maskBits(maskBits), .svcBits(svcBits),
    .autoBits(autoBits), .ackVector(ackVector)
  );

  vic_prio #(.N(NSRC), .IDX_W(IDX_W)) u_svcPrio (
    .bits(svcBits), .hit(svcHit), .idx(svcIdx)
  );

  assign groupFlag = modeReg[7] & (|(reqBits & ~maskBits));
  assign irqOut    = groupFlag & intEnable;

  always_comb begin
    case (modeReg[6:5])
      2'd0:    dataSel = svcBits;
      2'd1:    dataSel = maskBits;
      2'd2:    dataSel = reqBits;
      default: dataSel = autoBits;
    endcase
  end

  always_comb begin
    hostRdData = '0;
    if (hostSel) begin
      hostRdData[7] = groupFlag;
      hostRdData[6] = 1'b1;
      hostRdData[5] = modeReg[0];
      hostRdData[4] = modeReg[2];
      hostRdData[3] = modeReg[7];
      if (groupFlag && svcHit) hostRdData[2:0] = svcIdx;
    end else begin
      hostRdData[NSRC-1:0] = dataSel;
    end
  end
endmodule

// File: rtl/vic_intc_chk.sv
module vic_intc_chk #(
  parameter int NSRC   = 8,
  parameter int HOST_W = 16,
  parameter int VEC_W  = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              hostWrEn,
  input logic              hostSel,
  input logic [HOST_W-1:0] hostWrData,
  input logic [HOST_W-1:0] hostRdData,
  input logic [NSRC-1:0]   srcSet,
  input logic [NSRC-1:0]   srcClr,
  input logic              intAck,
  input logic [VEC_W-1:0]  ackVector,
  input logic              intEnable,
  input logic              irqOut,
  input logic [7:0]        modeReg,
  input logic [NSRC-1:0]   reqBits,
  input logic [NSRC-1:0]   maskBits,
  input logic [NSRC-1:0]   svcBits,
  input logic [NSRC-1:0]   autoBits
);
  // R9: the request output needs both the enable input and the master mask
  p_irq_gated_r9: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> (intEnable && modeReg[7]));

  // R8: the status word always reports the enabled bit
  p_status_enabled_r8: assert property (@(posedge clk) disable iff (!rstN)
    hostSel |-> hostRdData[6]);

  // R10: an acknowledge with no qualifying source returns vector 0
  p_noack_zero_r10: assert property (@(posedge clk) disable iff (!rstN)
    (intAck && ((reqBits & ~maskBits) == '0)) |-> (ackVector == '0));

  // R10: a granted acknowledge removes at least one pending request
  p_ack_drops_req_r10: assert property (@(posedge clk) disable iff (!rstN)
    (intAck && ((reqBits & ~maskBits) != '0) && (srcSet == '0))
      |=> ($countones(reqBits) < $countones($past(reqBits))));

  // R11: clear pulses leave request and in-service low
  p_clear_wins_r11: assert property (@(posedge clk) disable iff (!rstN)
    (srcClr != '0) |=> (((reqBits | svcBits) & $past(srcClr)) == '0));

  // R3: the reset command restores mask, in-service and auto-clear
  p_reset_cmd_r3: assert property (@(posedge clk) disable iff (!rstN)
    (hostWrEn && hostSel && hostWrData[7:4] == 4'd0 && !intAck)
      |=> (maskBits == '1 && svcBits == '0 && autoBits == '0));
endmodule

bind vic_intc vic_intc_chk #(.NSRC(vic_pkg::NSRC), .HOST_W(vic_pkg::HOST_W), .VEC_W(VEC_W)) u_chk (
  .clk(clk), .rstN(rstN), .hostWrEn(hostWrEn), .hostSel(hostSel),
  .hostWrData(hostWrData), .hostRdData(hostRdData), .srcSet(srcSet),
  .srcClr(srcClr), .intAck(intAck), .ackVector(ackVector),
  .intEnable(intEnable), .irqOut(irqOut), .modeReg(modeReg),
  .reqBits(reqBits), .maskBits(maskBits), .svcBits(svcBits),
  .autoBits(autoBits)
);

// File: tb/vic_intc_bench.sv
module vic_intc_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostWrEn = 1'b0;
  logic        hostSel = 1'b0;
  logic [15:0] hostWrData = '0;
  logic [15:0] hostRdData;
  logic [7:0]  srcSet = '0;
  logic [7:0]  srcClr = '0;
  logic        intAck = 1'b0;
  logic [15:0] ackVector;
  logic        intEnable = 1'b0;
  logic        irqOut;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  int mIrr, mImr, mIsr, mAcr, mMode, mKind, mIdx;
  int mVec[8];
  int lastRd, lastVec;
  bit lastIrq;

  always #(CLK_PERIOD/2) clk = ~clk;

  vic_intc u_vic_intc (
    .clk(clk), .rstN(rstN), .hostWrEn(hostWrEn), .hostSel(hostSel),
    .hostWrData(hostWrData), .hostRdData(hostRdData), .srcSet(srcSet),
    .srcClr(srcClr), .intAck(intAck), .ackVector(ackVector),
    .intEnable(intEnable), .irqOut(irqOut)
  );

  task automatic check(input bit ok, input string tag, input int got, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s got=0x%0h expected=0x%0h", tag, got, exp);
    end
  endtask

  function automatic int lowest(input int v);
    for (int i = 7; i >= 0; i--) if (v[i]) lowest = i;
    if (v == 0) lowest = -1;
  endfunction

  function automatic bit mGroup();
    return mMode[7] && ((mIrr & ~mImr & 'hFF) != 0);
  endfunction

  function automatic int mRead(input bit sel);
    int r, idx;
    if (sel) begin
      r = 'h40 | (mGroup() ? 'h80 : 0) | (mMode[0] ? 'h20 : 0) |
          (mMode[2] ? 'h10 : 0) | (mMode[7] ? 'h08 : 0);
      idx = lowest(mIsr);
      if (mGroup() && idx >= 0) r |= idx;
      return r;
    end
    case ((mMode >> 5) & 3)
      0: return mIsr;
      1: return mImr;
      2: return mIrr;
      default: return mAcr;
    endcase
  endfunction

  function automatic void mStep(input bit wr, input bit sel, input int d,
                                input bit ack, input int s, input int c);
    int win, b, code, preAcr;
    win = lowest(mIrr & ~mImr & 'hFF);
    preAcr = mAcr;
    b = d[3] ? (1 << (d & 7)) : 'hFF;
    code = (d >> 4) & 'hF;
    if (wr && sel) begin
      case (code)
        0: begin mImr = 'hFF; mIrr = 0; mIsr = 0; mAcr = 0; end
        2: begin mIrr &= ~b; mImr &= ~b; end
        3: mImr |= b;
        4: mIrr &= ~b;
        7: mIsr &= ~b;
        8, 9: mMode = (mMode & 'hE0) | (d & 'h1F);
        10: begin
          mMode = (mMode & ~'h60) | ((d & 'hC) << 3);
          if ((d & 3) == 1) mMode |= 'h80;
          if ((d & 3) == 2) mMode &= ~'h80;
        end
        11: mKind = 1;
        12: mKind = 2;
        14: begin mKind = 0; mIdx = d & 7; end
        default: ;
      endcase
    end
    if (wr && !sel) begin
      if (mKind == 1) mImr = d & 'hFF;
      else if (mKind == 2) mAcr = d & 'hFF;
      else mVec[mIdx] = d & 'hFFFF;
    end
    if (ack && win >= 0) begin
      mIrr &= ~(1 << win);
      if (preAcr[win]) mIsr &= ~(1 << win);
      else mIsr |= (1 << win);
    end
    mIrr = (mIrr | s) & ~c & 'hFF;
    mIsr = mIsr & ~c & 'hFF;
  endfunction

  task automatic tick(input bit wr, input bit sel, input int d, input bit ack,
                      input int s, input int c);
    int expVec, win;
    @(negedge clk);
    hostWrEn = wr; hostSel = sel; hostWrData = d[15:0];
    intAck = ack; srcSet = s[7:0]; srcClr = c[7:0];
    #1;
    lastRd = int'(hostRdData); lastIrq = irqOut; lastVec = int'(ackVector);
    check(lastIrq == (mGroup() && intEnable), "R9 irq model", lastIrq, mGroup() && intEnable);
    if (sel) check(lastRd == mRead(1), "R8 status model", lastRd, mRead(1));
    else     check(lastRd == mRead(0), "R7 data model", lastRd, mRead(0));
    if (ack) begin
      win = lowest(mIrr & ~mImr & 'hFF);
      expVec = (win >= 0) ? mVec[win] : 0;
      check(lastVec == expVec, "R10 vector model", lastVec, expVec);
    end
    @(posedge clk);
    mStep(wr, sel, d, ack, s, c);
    @(negedge clk);
    hostWrEn = 0; intAck = 0; srcSet = 0; srcClr = 0;
  endtask

  task automatic cmd(input int d);
    tick(1, 1, d, 0, 0, 0);
  endtask

  task automatic expectRead(input bit sel, input int exp, input string tag);
    tick(0, sel, 0, 0, 0, 0);
    check(lastRd == exp, tag, lastRd, exp);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    mIrr = 0; mImr = 'hFF; mIsr = 0; mAcr = 0; mMode = 'h80; mKind = 0; mIdx = 0;
    foreach (mVec[i]) mVec[i] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;

    // R1 reset state
    expectRead(1, 'h48, "R1 status after reset");
    expectRead(0, 'h00, "R1 in-service after reset");
    cmd('hA4);                                   // R6 preselect field -> mask
    expectRead(0, 'hFF, "R1 mask after reset (R7 select 1)");

    // R5 vector loading through preselect
    for (int i = 0; i < 8; i++) begin
      cmd('hE0 | i);
      tick(1, 0, 'h100 + i * 3, 0, 0, 0);
    end
    cmd('h20);                                   // R4 clear request+mask all
    expectRead(0, 'h00, "R4 mask cleared all");

    tick(0, 0, 0, 0, 'hA4, 0);                   // R11 set pulses
    intEnable = 1'b0;
    tick(0, 1, 0, 0, 0, 0);
    check(lastIrq == 0, "R9 irq gated by enable", lastIrq, 0);
    intEnable = 1'b1;
    expectRead(1, 'hC8, "R8 group status");
    check(lastIrq == 1, "R9 irq with enable", lastIrq, 1);

    cmd('h3A);                                   // R2 single-bit set mask 2
    expectRead(0, 'h04, "R2 single mask bit");
    tick(0, 1, 0, 1, 0, 0);
    check(lastVec == 'h10F, "R10 winner vector 5", lastVec, 'h10F);
    expectRead(1, 'hCD, "R8 lowest in-service index");

    cmd('hC0);                                   // R5 preselect auto-clear
    tick(1, 0, 'h0080, 0, 0, 0);
    tick(0, 1, 0, 1, 0, 0);
    check(lastVec == 'h115, "R10 winner vector 7", lastVec, 'h115);
    cmd('hA0);
    expectRead(0, 'h20, "R10 auto-clear keeps in-service low");
    tick(0, 1, 0, 1, 0, 0);
    check(lastVec == 0, "R10 masked only gives zero", lastVec, 0);
    cmd('hA8);
    expectRead(0, 'h04, "R10 masked request kept");

    cmd('h60); cmd('h5F); cmd('h1F); cmd('hDF); cmd('hFF);
    expectRead(0, 'h04, "R4 unlisted codes no effect");

    tick(0, 0, 0, 0, 'h10, 'h10);
    expectRead(0, 'h04, "R11 clear beats set");
    cmd('hA0);
    tick(0, 0, 0, 0, 0, 'h20);
    expectRead(0, 'h00, "R11 clear pulse drops in-service");

    cmd('h95);                                   // R6 load mode low bits
    expectRead(1, 'h78, "R6 mode bits in status");
    cmd('hA2);                                   // R6 master mask off
    cmd('h20);
    tick(0, 0, 0, 0, 'h01, 0);
    expectRead(1, 'h70, "R9 master mask off");
    check(lastIrq == 0, "R9 irq low with master off", lastIrq, 0);
    cmd('hA3);                                   // R6 code 11 leaves master
    expectRead(1, 'h70, "R6 code 11 ignored for master");
    cmd('hA1);
    expectRead(1, 'hF8, "R6 master on");
    cmd('h48);                                   // R2 clear request bit 0
    expectRead(1, 'h78, "R2 single clear request");
    cmd('h30); cmd('hA4);
    expectRead(0, 'hFF, "R2 set mask all");
    cmd('h2B);
    expectRead(0, 'hF7, "R2 clear mask bit 3");

    cmd('h00);                                   // R3 reset command
    expectRead(0, 'hFF, "R3 mask all ones");
    expectRead(1, 'h78, "R3 mode kept");
    cmd('hAC);
    expectRead(0, 'h00, "R3 auto-clear zero");

    for (int n = 0; n < 600; n++) begin
      int r, d;
      r = $urandom_range(0, 9);
      d = $urandom_range(0, 'hFFFF);
      intEnable = $urandom_range(0, 3) != 0;
      case (r)
        0, 1: tick(1, 1, d, 0, 0, 0);
        2:    tick(1, 0, d, 0, 0, 0);
        3, 4: tick(0, r[0], 0, 1, $urandom_range(0, 255) & $urandom_range(0, 255), 0);
        5:    tick(0, 0, 0, 0, $urandom_range(0, 255), $urandom_range(0, 255) & $urandom_range(0, 255));
        6:    tick(1, 1, 'h20 | (d & 'hF), 1, 0, 0);
        default: tick(0, d[0], 0, 0, $urandom_range(0, 255), 0);
      endcase
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule